// File: doc/BRIEF.md
# Three-Wire Serial Register Slave

This block lets an external host reach an on-chip register file over a three-wire serial link: a chip-select, a serial clock and one bidirectional data line. The data line is modelled as a separate input, an output and an output enable, so the pad tri-state lives outside the block. All three link inputs are synchronised into the system clock domain, and the serial clock is handled by edge detection. It is never used as a clock.

A transfer opens when chip-select rises and is ended by chip-select falling. The first eight serial bits are a command. Its low seven bits name a register and its top bit gives the direction. The next eight bits are the data, written in by the host or returned by the block. Register accesses leave the block as single-cycle strobes on a parallel address/data port. The control register is kept inside the block. It drives the rest of the chip and holds a write-protect bit that gates every register write. After reset the block ignores the link for a fixed power-up interval.

Top module: `ser3_reg_slave`

## Requirements
- R1: Serial bits are sampled on rising edges of `sclk_i` while `cs_i` is high, least significant bit first. In the first byte, bits 0..6 are the register address, and bit 7 is 1 for a write and 0 for a read.
- R2: On a read, the block drives the addressed byte on `sdio_o` LSB first. Each bit changes after a falling `sclk_i` edge, starting with the falling edge that follows the eighth rising edge, so the host samples it on rising edges 9 to 16.
- R3: On a write, after the sixteenth rising edge the block issues exactly one single-cycle `reg_we_o` pulse, with `reg_addr_o` and `reg_wdata_o` carrying the command address and the data byte. A read of an external register issues one `reg_re_o` pulse and never `reg_we_o`.
- R4: While control bit 6 (write protect) is 1, no `reg_we_o` is issued. A write to the control register under protection changes only bit 6, so writing bit 6 as 0 always releases the protection.
- R5: Addresses 0x0F to 0x7F are reserved. Reads of them return 0x00, writes to them are dropped, and neither produces a strobe.
- R6: For `PWRUP_CYCLES` clock cycles after reset, and for any transfer whose chip-select rose inside that interval, no strobe is issued and no control register change happens.
- R7: If `cs_i` falls before the sixteenth rising edge, the transfer is abandoned with no write. The next transfer is decoded from a fresh command byte.
- R8: `sdio_oe_o` is high only during the data phase of a read. It is low during the command byte, during writes, and within a few cycles after `cs_i` falls.
- R9: The control register sits at address 0x0E, resets to 0x00, reads back over the link, and is presented on `ctrl_o`.
- R10: Out of reset, `sdio_oe_o`, `reg_we_o` and `reg_re_o` are low and `ctrl_o` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_i | input | 1 | Link chip-select, high during a transfer |
| sclk_i | input | 1 | Link serial clock |
| sdio_i | input | 1 | Data line as seen at the pad |
| sdio_o | output | 1 | Data driven toward the pad |
| sdio_oe_o | output | 1 | Pad output enable |
| reg_addr_o | output | 7 | Register file address |
| reg_wdata_o | output | 8 | Register file write data |
| reg_we_o | output | 1 | Register file write strobe |
| reg_re_o | output | 1 | Register file read strobe |
| reg_rdata_i | input | 8 | Register file read data, valid in the `reg_re_o` cycle |
| ctrl_o | output | 8 | Control register contents |

## Verification
A wrong bit counter or a wrong shift register shows up in the next read of the same register. The returned byte comes back rotated, shifted or taken from the wrong address within a single transfer. A decode error on protection, reserved space or the control register appears as an extra or missing write strobe, which changes the read-back value on the next transfer. Output-enable errors appear at once on `sdio_oe_o` during the command phase or after chip-select falls. A late-arming fault in the power-up gate shows as a write that takes effect too early.

// File: rtl/ser3_pkg.sv
package ser3_pkg;
  localparam int unsigned ADDR_W = 7;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned BITS_W = $clog2(2 * DATA_W + 1);

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] byte_t;

  // command byte: MSB is direction (1 = write)
  typedef struct packed {
    logic  wr;
    addr_t addr;
  } cmd_t;
endpackage

// File: rtl/ser3_sync.sv
module ser3_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= '0;
    end else begin
      st_q[0] <= d_i;
      for (int k = 1; k < int'(STAGES); k++) st_q[k] <= st_q[k-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/ser3_pwrup.sv
module ser3_pwrup #(
  parameter int unsigned CYCLES = 2000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic ready_o
);
  localparam int unsigned CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q;
  logic          ready_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      ready_q <= 1'b0;
    end else if (!ready_q) begin
      if (cnt_q == CW'(CYCLES - 1)) ready_q <= 1'b1;
      else                          cnt_q   <= cnt_q + 1'b1;
    end
  end

  assign ready_o = ready_q;
endmodule

// File: rtl/ser3_shift.sv
module ser3_shift
  import ser3_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  ready_i,
  input  logic  cs_i,
  input  logic  sclk_i,
  input  logic  sdi_i,
  output logic  sdo_o,
  output logic  oe_o,
  output logic  rd_req_o,
  output logic  wr_req_o,
  output cmd_t  cmd_o,
  output byte_t wdata_o,
  input  byte_t rd_data_i
);
  localparam logic [BITS_W-1:0] CMD_LAST = BITS_W'(DATA_W - 1);
  localparam logic [BITS_W-1:0] DAT_LAST = BITS_W'(2 * DATA_W - 1);
  localparam logic [BITS_W-1:0] DAT_FST  = BITS_W'(DATA_W);
  localparam logic [BITS_W-1:0] DONE     = BITS_W'(2 * DATA_W);

  logic              cs_d, sclk_d, act_q;
  logic [BITS_W-1:0] cnt_q;
  byte_t             rx_q, tx_q, wdata_q;
  cmd_t              cmd_q;
  logic              rd_req_q, wr_req_q, sdo_q, oe_q;

  logic  rise, fall, cs_rise;
  byte_t rx_nxt;

  assign rise    = sclk_i & ~sclk_d;
  assign fall    = ~sclk_i & sclk_d;
  assign cs_rise = cs_i & ~cs_d;
  assign rx_nxt  = {sdi_i, rx_q[DATA_W-1:1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_d     <= 1'b0;
      sclk_d   <= 1'b0;
      act_q    <= 1'b0;
      cnt_q    <= '0;
      rx_q     <= '0;
      tx_q     <= '0;
      wdata_q  <= '0;
      cmd_q    <= '0;
      rd_req_q <= 1'b0;
      wr_req_q <= 1'b0;
      sdo_q    <= 1'b0;
      oe_q     <= 1'b0;
    end else begin
      cs_d     <= cs_i;
      sclk_d   <= sclk_i;
      rd_req_q <= 1'b0;
      wr_req_q <= 1'b0;
      if (!cs_i) begin
        act_q <= 1'b0;
        cnt_q <= '0;
        oe_q  <= 1'b0;
        sdo_q <= 1'b0;
      end else if (!act_q) begin
        // arm only on a chip-select edge seen after power-up
        if (cs_rise && ready_i) begin
          act_q <= 1'b1;
          cnt_q <= '0;
        end
      end else begin
        if (rise && cnt_q != DONE) begin
          rx_q  <= rx_nxt;
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CMD_LAST) begin
            cmd_q    <= cmd_t'(rx_nxt);
            rd_req_q <= ~rx_nxt[DATA_W-1];
          end
          if (cnt_q == DAT_LAST && cmd_q.wr) begin
            wdata_q  <= rx_nxt;
            wr_req_q <= 1'b1;
          end
        end
        if (fall && !cmd_q.wr && cnt_q >= DAT_FST && cnt_q != DONE) begin
          sdo_q <= tx_q[0];
          tx_q  <= tx_q >> 1;
          oe_q  <= 1'b1;
        end
        if (rd_req_q) tx_q <= rd_data_i;
      end
    end
  end

  assign sdo_o    = sdo_q;
  assign oe_o     = oe_q;
  assign rd_req_o = rd_req_q;
  assign wr_req_o = wr_req_q;
  assign cmd_o    = cmd_q;
  assign wdata_o  = wdata_q;
endmodule

// File: rtl/ser3_regs.sv
module ser3_regs
  import ser3_pkg::*;
#(
  parameter addr_t       CTRL_ADDR = 7'h0E,
  parameter addr_t       RSV_BASE  = 7'h0F,
  parameter int unsigned WP_BIT    = 6,
  parameter byte_t       CTRL_RST  = 8'h00
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  rd_req_i,
  input  logic  wr_req_i,
  input  addr_t addr_i,
  input  byte_t wdata_i,
  output byte_t rd_data_o,
  output byte_t ctrl_o,
  output addr_t reg_addr_o,
  output byte_t reg_wdata_o,
  output logic  reg_we_o,
  output logic  reg_re_o,
  input  byte_t reg_rdata_i
);
  byte_t ctrl_q;
  logic  is_rsv, is_ctrl, is_ext, wp;

  assign is_rsv  = addr_i >= RSV_BASE;
  assign is_ctrl = !is_rsv && addr_i == CTRL_ADDR;
  assign is_ext  = !is_rsv && !is_ctrl;
  assign wp      = ctrl_q[WP_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= CTRL_RST;
    end else if (wr_req_i && is_ctrl) begin
      // under protection only the protect bit may change
      if (wp) ctrl_q[WP_BIT] <= wdata_i[WP_BIT];
      else    ctrl_q         <= wdata_i;
    end
  end

  always_comb begin
    if (is_rsv)       rd_data_o = '0;
    else if (is_ctrl) rd_data_o = ctrl_q;
    else              rd_data_o = reg_rdata_i;
  end

  assign reg_addr_o  = addr_i;
  assign reg_wdata_o = wdata_i;
  assign reg_re_o    = rd_req_i && is_ext;
  assign reg_we_o    = wr_req_i && is_ext && !wp;
  assign ctrl_o      = ctrl_q;
endmodule

// File: rtl/ser3_reg_slave.sv
module ser3_reg_slave
  import ser3_pkg::*;
#(
  parameter int unsigned PWRUP_CYCLES = 2000,
  parameter int unsigned SYNC_STAGES  = 2,
  parameter addr_t       CTRL_ADDR    = 7'h0E,
  parameter addr_t       RSV_BASE     = 7'h0F,
  parameter int unsigned WP_BIT       = 6,
  parameter byte_t       CTRL_RST     = 8'h00
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cs_i,
  input  logic       sclk_i,
  input  logic       sdio_i,
  output logic       sdio_o,
  output logic       sdio_oe_o,
  output logic [6:0] reg_addr_o,
  output logic [7:0] reg_wdata_o,
  output logic       reg_we_o,
  output logic       reg_re_o,
  input  logic [7:0] reg_rdata_i,
  output logic [7:0] ctrl_o
);
  logic [2:0] pins_s;
  logic       pwr_ok, rd_req, wr_req;
  cmd_t       cmd;
  byte_t      wdata, rd_data;

  ser3_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({cs_i, sclk_i, sdio_i}),
    .q_o    (pins_s)
  );

  ser3_pwrup #(.CYCLES(PWRUP_CYCLES)) u_pwrup (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ready_o (pwr_ok)
  );

  ser3_shift u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ready_i   (pwr_ok),
    .cs_i      (pins_s[2]),
    .sclk_i    (pins_s[1]),
    .sdi_i     (pins_s[0]),
    .sdo_o     (sdio_o),
    .oe_o      (sdio_oe_o),
    .rd_req_o  (rd_req),
    .wr_req_o  (wr_req),
    .cmd_o     (cmd),
    .wdata_o   (wdata),
    .rd_data_i (rd_data)
  );

  ser3_regs #(
    .CTRL_ADDR (CTRL_ADDR),
    .RSV_BASE  (RSV_BASE),
    .WP_BIT    (WP_BIT),
    .CTRL_RST  (CTRL_RST)
  ) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_req_i    (rd_req),
    .wr_req_i    (wr_req),
    .addr_i      (cmd.addr),
    .wdata_i     (wdata),
    .rd_data_o   (rd_data),
    .ctrl_o      (ctrl_o),
    .reg_addr_o  (reg_addr_o),
    .reg_wdata_o (reg_wdata_o),
    .reg_we_o    (reg_we_o),
    .reg_re_o    (reg_re_o),
    .reg_rdata_i (reg_rdata_i)
  );
endmodule

// File: rtl/ser3_reg_slave_chk.sv
module ser3_reg_slave_chk #(
  parameter logic [6:0]  RSV_BASE    = 7'h0F,
  parameter int unsigned WP_BIT      = 6,
  parameter int unsigned SYNC_STAGES = 2
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cs_i,
  input logic       sdio_oe_o,
  input logic       reg_we_o,
  input logic       reg_re_o,
  input logic [6:0] reg_addr_o,
  input logic [7:0] ctrl_o,
  input logic       pwr_ok
);
  localparam logic [7:0] KEEP = ~(8'h01 << WP_BIT);
  localparam int unsigned LOW_W = 4;
  localparam logic [LOW_W-1:0] LOW_LIM = LOW_W'(SYNC_STAGES + 1);

  logic [LOW_W-1:0] cs_low_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cs_low_q <= '0;
    else if (cs_i)            cs_low_q <= '0;
    else if (cs_low_q != '1)  cs_low_q <= cs_low_q + 1'b1;
  end

  AST_NO_STROBE_EARLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_ok |-> !(reg_we_o || reg_re_o)); // R6
  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_we_o && reg_re_o)); // R3
  AST_WE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> !reg_we_o); // R3
  AST_RSV_NO_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_o || reg_re_o) |-> (reg_addr_o < RSV_BASE)); // R5
  AST_WP_HOLDS_CTRL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_o[WP_BIT] |=> ((ctrl_o & KEEP) == $past(ctrl_o & KEEP))); // R4
  AST_OE_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_low_q >= LOW_LIM) |-> !sdio_oe_o); // R8
endmodule

bind ser3_reg_slave ser3_reg_slave_chk #(
  .RSV_BASE    (RSV_BASE),
  .WP_BIT      (WP_BIT),
  .SYNC_STAGES (SYNC_STAGES)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cs_i       (cs_i),
  .sdio_oe_o  (sdio_oe_o),
  .reg_we_o   (reg_we_o),
  .reg_re_o   (reg_re_o),
  .reg_addr_o (reg_addr_o),
  .ctrl_o     (ctrl_o),
  .pwr_ok     (pwr_ok)
);

// File: tb/sim_ser3_reg_slave.sv
`timescale 1ns/1ps
module sim_ser3_reg_slave;
  localparam int HALF = 8;
  localparam logic [6:0] CTRL = 7'h0E;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs = 1'b0, sclk = 1'b0, sdi = 1'b0;
  logic       sdo, oe, we, re;
  logic [6:0] raddr;
  logic [7:0] wdat, rdat, ctrl;

  logic [7:0] mem [0:127];
  logic [7:0] exp_mem [0:127];
  logic [7:0] exp_ctrl;
  int total = 0, bad = 0, we_cnt = 0, re_cnt = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ser3_reg_slave u0 (
    .clk_i (clk), .rst_ni (rst_n), .cs_i (cs), .sclk_i (sclk), .sdio_i (sdi),
    .sdio_o (sdo), .sdio_oe_o (oe), .reg_addr_o (raddr), .reg_wdata_o (wdat),
    .reg_we_o (we), .reg_re_o (re), .reg_rdata_i (rdat), .ctrl_o (ctrl)
  );

  assign rdat = mem[raddr];

  always @(negedge clk) begin
    if (we) begin mem[raddr] = wdat; we_cnt++; end
    if (re) re_cnt++;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exv);
    end
  endtask

  function automatic logic [7:0] exp_read(input logic [6:0] a);
    if (a >= 7'h0F) return 8'h00;
    if (a == CTRL) return exp_ctrl;
    return exp_mem[a];
  endfunction

  task automatic model_write(input logic [6:0] a, input logic [7:0] d);
    if (a >= 7'h0F) return;
    if (a == CTRL) begin
      if (exp_ctrl[6]) exp_ctrl[6] = d[6];
      else exp_ctrl = d;
    end else if (!exp_ctrl[6]) exp_mem[a] = d;
  endtask

  task automatic pulse_sclk();
    repeat (HALF) @(negedge clk);
    sclk = 1'b1;
    repeat (HALF) @(negedge clk);
    sclk = 1'b0;
  endtask

  // nbits < 16 drops chip-select early
  task automatic xfer(input logic wr, input logic [6:0] a, input logic [7:0] d,
                      input int nbits, output logic [7:0] rd, output logic oe_bad);
    logic [7:0] cmd;
    cmd = {wr, a};
    rd = 8'h00;
    oe_bad = 1'b0;
    @(negedge clk); cs = 1'b1;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      if (i < nbits) begin
        sdi = cmd[i];
        if (oe) oe_bad = 1'b1;
        pulse_sclk();
      end
    end
    for (int i = 0; i < 8; i++) begin
      if (8 + i < nbits) begin
        if (wr) begin
          sdi = d[i];
          if (oe) oe_bad = 1'b1;
          pulse_sclk();
        end else begin
          repeat (HALF) @(negedge clk);
          rd[i] = sdo;
          if (!oe) oe_bad = 1'b1;
          sclk = 1'b1;
          repeat (HALF) @(negedge clk);
          sclk = 1'b0;
        end
      end
    end
    repeat (4) @(negedge clk);
    cs = 1'b0;
    repeat (6) @(negedge clk);
    if (oe) oe_bad = 1'b1;
  endtask

  task automatic do_write(input logic [6:0] a, input logic [7:0] d, input string req);
    logic [7:0] rd; logic ob; int w0; int ew;
    w0 = we_cnt;
    ew = (a < 7'h0F && a != CTRL && !exp_ctrl[6]) ? 1 : 0;
    xfer(1'b1, a, d, 16, rd, ob);
    model_write(a, d);
    chk(!ob, {req, " R8 oe during write"}, 32'(ob), 0);
    chk(we_cnt - w0 == ew, {req, " R3 write strobe count"}, we_cnt - w0, ew);
  endtask

  task automatic do_read(input logic [6:0] a, input string req);
    logic [7:0] rd; logic ob; int r0; int er;
    r0 = re_cnt;
    er = (a < 7'h0F && a != CTRL) ? 1 : 0;
    xfer(1'b0, a, 8'h00, 16, rd, ob);
    chk(rd == exp_read(a), {req, " R2 read data"}, rd, exp_read(a));
    chk(!ob, {req, " R8 oe during read"}, 32'(ob), 0);
    chk(re_cnt - r0 == er, {req, " R3 read strobe count"}, re_cnt - r0, er);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=%h exp=%h", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd; logic ob; int w0;
    int unsigned seed;
    for (int i = 0; i < 128; i++) begin
      mem[i] = 8'(i * 37 + 11);
      exp_mem[i] = 8'(i * 37 + 11);
    end
    exp_ctrl = 8'h00;
    repeat (3) @(negedge clk);
    chk(oe == 1'b0 && we == 1'b0 && re == 1'b0, "R10 reset outputs", {oe, we, re}, 0);
    chk(ctrl == 8'h00, "R10 R9 reset ctrl", ctrl, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R6: transfer during power-up interval is ignored
    w0 = we_cnt;
    xfer(1'b1, 7'h03, 8'h5A, 16, rd, ob);
    chk(we_cnt == w0, "R6 no write before ready", we_cnt - w0, 0);
    xfer(1'b1, CTRL, 8'hFF, 16, rd, ob);
    chk(ctrl == 8'h00, "R6 ctrl untouched before ready", ctrl, 0);
    repeat (2100) @(negedge clk);
    do_read(7'h03, "R6 value kept");

    // R1 R3 directed write and readback
    do_write(7'h03, 8'hA5, "R1");
    do_read(7'h03, "R1");
    do_write(7'h00, 8'h01, "R1 lsb");
    do_read(7'h00, "R1 lsb");
    do_write(7'h0D, 8'h80, "R1 msb");
    do_read(7'h0D, "R1 msb");

    // R5 reserved space
    do_write(7'h0F, 8'h77, "R5 low edge");
    do_read(7'h0F, "R5 low edge");
    do_write(7'h7F, 8'hFF, "R5 top");
    do_read(7'h7F, "R5 top");
    do_read(7'h40, "R5 mid");

    // R9 control register
    do_write(CTRL, 8'h3C, "R9");
    chk(ctrl == 8'h3C, "R9 ctrl_o", ctrl, 8'h3C);
    do_read(CTRL, "R9");

    // R4 write protect
    do_write(CTRL, 8'hC1, "R4 set wp");
    chk(ctrl == 8'hC1, "R4 ctrl after set", ctrl, 8'hC1);
    do_write(7'h05, 8'h11, "R4 blocked");
    do_read(7'h05, "R4 blocked");
    do_write(CTRL, 8'hFF, "R4 ctrl under wp");
    chk(ctrl == 8'hC1, "R4 ctrl only wp bit", ctrl, 8'hC1);
    do_write(CTRL, 8'h00, "R4 release");
    chk(ctrl == 8'h81, "R4 wp cleared", ctrl, 8'h81);
    do_write(7'h05, 8'h22, "R4 unblocked");
    do_read(7'h05, "R4 unblocked");

    // R7 abort
    w0 = we_cnt;
    xfer(1'b1, 7'h06, 8'h99, 12, rd, ob);
    chk(we_cnt == w0, "R7 abort no write", we_cnt - w0, 0);
    xfer(1'b1, 7'h06, 8'h99, 5, rd, ob);
    chk(we_cnt == w0, "R7 abort in command", we_cnt - w0, 0);
    do_read(7'h06, "R7 fresh command");

    // random mix
    seed = 32'h00C0FFEE;
    void'($urandom(seed));
    for (int n = 0; n < 60; n++) begin
      logic [6:0] a; logic [7:0] d; int pick;
      pick = int'($urandom % 20);
      a = (pick < 15) ? 7'(pick) : 7'($urandom % 128);
      d = 8'($urandom);
      if ($urandom % 2 == 0) do_write(a, d, "R1 rnd");
      else do_read(a, "R2 rnd");
    end
    for (int i = 0; i < 15; i++) do_read(7'(i), "R3 final sweep");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule